// File: doc/BRIEF.md
# Split-Mode Event Counter Bank

This block holds four physical 32-bit event counters behind a small register bus. Each physical counter runs either as one 32-bit counter or as two separate 16-bit halves, so software sees up to eight logical counters. A single run bit in the control register starts and stops all counting. Each physical counter has its own split bit in the same register.

Software never writes a live counter directly. A counter write fills a staging latch for that counter. The live counter keeps counting its old value until the control register is written with the run bit set. That write copies every pending latch into its live counter, and it does so even when the bank is already running. Overflow of a counter, or of a counter half, raises a sticky flag when that flag's interrupt enable is set. The interrupt line is the OR of all flags that are set and enabled. Reading the status register returns the flags and clears them in the same access.

The register bus carries 64-bit words, and each register sits in the upper 32 bits. Word addresses are: 0 = control, 1 = status, 2..5 = physical counters 0..3. Events arrive on an eight-bit input with one bit per logical counter.

Top module: `pcb_bank`

## Requirements
- R1: After reset all counters, staging latches, the control register, the flags and the interrupt mask read zero, the bank is stopped and `irq_o` is low.
- R2: With the run bit (control bit 31) set and split bit p (control bit p) clear, physical counter p adds one for each cycle in which `evt_i[p]` is high, and `evt_i[p+4]` has no effect on it. With the run bit clear, no counter changes.
- R3: With split bit p set, the upper 16 bits of counter p count `evt_i[p]` and the lower 16 bits count `evt_i[p+4]`. Each half wraps from 0xFFFF to 0 without carrying into the other half.
- R4: A write to a counter address stores the value in that counter's staging latch only. A read of the counter returns the live value, not the latch.
- R5: A control write with bit 31 set loads every pending latch into its live counter. This also happens when the bank is already running and the control value is unchanged.
- R6: A control write with bit 31 clear stops counting and leaves pending latches uncommitted. The latches are loaded by a later control write with bit 31 set.
- R7: A wrap from all-ones to zero sets a status flag only if the interrupt enable bit of that flag is set. In 32-bit mode counter p uses flag bit p. In split mode the upper half uses flag bit p and the lower half uses flag bit p+4.
- R8: A read of the status address returns the flags in bits [7:0] of the register and clears them. Between reads the flags stay set.
- R9: A write to the status address loads the interrupt enable mask from bits [7:0]. `irq_o` is high exactly when some flag is both set and enabled, so writing zero drops `irq_o` in the next cycle.
- R10: Register data sits in bits [63:32] of the bus word. Bits [31:0] are ignored on writes and read as zero. Read data and `bus_rvalid_o` appear in the cycle after a read request. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Register access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address of the register |
| bus_wdata_i | input | 64 | Write data, register value in [63:32] |
| bus_rdata_o | output | 64 | Read data, register value in [63:32] |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the request |
| evt_i | input | 8 | One event bit per logical counter |
| irq_o | output | 1 | Interrupt, OR of enabled pending flags |

## Verification
Counting is driven with the events of both halves of a counter active together while the counter is in 32-bit mode. This shows whether the lower-half event leaks into an unsplit counter. Split mode is driven from a lower half sitting just below its wrap point, so a carry into the upper half cannot be mistaken for correct counting. Staged writes are tried in three conditions: while running, with an unchanged control rewrite, and while stopped. These separate "latch only" from "write through" and "commit on run" from "commit on any control write". Overflows are produced with the interrupt mask both open and closed, and the status is read twice, which separates gated flag setting from read-to-clear.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int CNT_BASE = 2;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          split_i,
    input  logic          evt_hi_i,
    input  logic          evt_lo_i,
    input  logic          wr_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          commit_i,
    output logic [CW-1:0] value_o,
    output logic          wrap_hi_o,
    output logic          wrap_lo_o
);
    localparam int HW = CW / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] latch;
        logic          pend;
    } cnt_st_t;

    cnt_st_t st_q, st_d;
    logic          load_w;
    logic [HW:0]   hi_sum;
    logic [HW:0]   lo_sum;
    logic [CW:0]   full_sum;

    always_comb begin
        load_w    = commit_i && st_q.pend;
        hi_sum    = {1'b0, st_q.cnt[CW-1:HW]} + {{HW{1'b0}}, evt_hi_i};
        lo_sum    = {1'b0, st_q.cnt[HW-1:0]}  + {{HW{1'b0}}, evt_lo_i};
        full_sum  = {1'b0, st_q.cnt} + {{CW{1'b0}}, evt_hi_i};
        st_d      = st_q;
        wrap_hi_o = 1'b0;
        wrap_lo_o = 1'b0;
        if (load_w) begin
            st_d.cnt  = st_q.latch;
            st_d.pend = 1'b0;
        end else if (run_i) begin
            if (split_i) begin
                st_d.cnt  = {hi_sum[HW-1:0], lo_sum[HW-1:0]};
                wrap_hi_o = hi_sum[HW];
                wrap_lo_o = lo_sum[HW];
            end else begin
                st_d.cnt  = full_sum[CW-1:0];
                wrap_hi_o = full_sum[CW];
            end
        end
        if (wr_i) begin
            st_d.latch = wdata_i;
            st_d.pend  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value_o = st_q.cnt;

    AST_WRITE_NOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !run_i && !commit_i) |=> $stable(value_o)) else $error("latch write reached live counter"); // R4
    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && st_q.pend) |=> (value_o == $past(st_q.latch))) else $error("commit did not load latch"); // R5
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !commit_i) |=> $stable(value_o)) else $error("stopped counter moved"); // R6
    AST_NO_HALF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (split_i && run_i && !commit_i && !evt_hi_i) |=> (value_o[CW-1:HW] == $past(value_o[CW-1:HW]))) else $error("carry into upper half"); // R3
endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
    parameter int NL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] wrap_i,
    input  logic          rd_clr_i,
    input  logic          mask_wr_i,
    input  logic [NL-1:0] mask_i,
    output logic [NL-1:0] flags_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [NL-1:0] flags;
        logic [NL-1:0] mask;
    } stat_st_t;

    stat_st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (rd_clr_i ? '0 : st_q.flags) | (wrap_i & st_q.mask);
        if (mask_wr_i) st_d.mask = mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & st_q.mask);

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (wrap_i == '0)) |=> (flags_o == '0)) else $error("flags survived read"); // R8
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))) else $error("flag dropped without read"); // R8
    AST_MASKED_WRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && ((wrap_i & st_q.mask) == '0)) |=> (flags_o == '0)) else $error("masked wrap set a flag"); // R7
endmodule

// File: rtl/pcb_bank.sv
module pcb_bank #(
    parameter int NUM_PHYS = 4,
    parameter int DW       = 32,
    parameter int BW       = 64,
    parameter int ADDR_W   = $clog2(NUM_PHYS + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid_i,
    input  logic                  bus_write_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [BW-1:0]         bus_wdata_i,
    output logic [BW-1:0]         bus_rdata_o,
    output logic                  bus_rvalid_o,
    input  logic [2*NUM_PHYS-1:0] evt_i,
    output logic                  irq_o
);
    import pcb_pkg::*;

    localparam int NL = 2 * NUM_PHYS;

    typedef struct packed {
        logic                run;
        logic [NUM_PHYS-1:0] split;
        logic [DW-1:0]       rdata;
        logic                rvalid;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [DW-1:0]       wdat_w;
    logic                ctrl_wr_w;
    logic                commit_w;
    logic                stat_rd_w;
    logic                stat_wr_w;
    logic [NL-1:0]       wrap_w;
    logic [NL-1:0]       flags_w;
    logic [DW-1:0]       cnt_val [NUM_PHYS];
    logic [DW-1:0]       rd_mux_w;
    logic                unused_low_w;

    assign wdat_w       = bus_wdata_i[BW-1:BW-DW];
    assign unused_low_w = ^bus_wdata_i[BW-DW-1:0];
    assign ctrl_wr_w    = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(REG_CTRL));
    assign commit_w     = ctrl_wr_w && wdat_w[DW-1];
    assign stat_rd_w    = bus_valid_i && !bus_write_i && (bus_addr_i == ADDR_W'(REG_STAT));
    assign stat_wr_w    = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(REG_STAT));

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_ctr
        logic wr_p;
        assign wr_p = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(CNT_BASE + p));
        pcb_counter #(.CW(DW)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (st_q.run),
            .split_i   (st_q.split[p]),
            .evt_hi_i  (evt_i[p]),
            .evt_lo_i  (evt_i[p+NUM_PHYS]),
            .wr_i      (wr_p),
            .wdata_i   (wdat_w),
            .commit_i  (commit_w),
            .value_o   (cnt_val[p]),
            .wrap_hi_o (wrap_w[p]),
            .wrap_lo_o (wrap_w[p+NUM_PHYS])
        );
    end

    pcb_status #(.NL(NL)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap_w),
        .rd_clr_i  (stat_rd_w),
        .mask_wr_i (stat_wr_w),
        .mask_i    (wdat_w[NL-1:0]),
        .flags_o   (flags_w),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_mux_w = '0;
        if (bus_addr_i == ADDR_W'(REG_CTRL))
            rd_mux_w = {st_q.run, {(DW-1-NUM_PHYS){1'b0}}, st_q.split};
        else if (bus_addr_i == ADDR_W'(REG_STAT))
            rd_mux_w = {{(DW-NL){1'b0}}, flags_w};
        for (int p = 0; p < NUM_PHYS; p++)
            if (bus_addr_i == ADDR_W'(CNT_BASE + p)) rd_mux_w = cnt_val[p];
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_valid_i && !bus_write_i;
        if (bus_valid_i && !bus_write_i) st_d.rdata = rd_mux_w;
        if (ctrl_wr_w) begin
            st_d.run   = wdat_w[DW-1];
            st_d.split = wdat_w[NUM_PHYS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata_o  = {st_q.rdata, {(BW-DW){1'b0}}};
    assign bus_rvalid_o = st_q.rvalid;

    AST_READ_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i) |=> bus_rvalid_o) else $error("read data late"); // R10
    AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> (bus_rdata_o[BW-DW-1:0] == '0)) else $error("low half not zero"); // R10
    AST_MASK_ZERO_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_w && (wdat_w[NL-1:0] == '0)) |=> !irq_o) else $error("irq after zero mask"); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!irq_o && !bus_rvalid_o)) else $error("outputs active after reset"); // R1
endmodule

// File: tb/pcb_bank_bench.sv
`timescale 1ns/1ps
module pcb_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  evt = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pcb_bank u_pcb_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid_i  (bus_valid),
        .bus_write_i  (bus_write),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .bus_rvalid_o (bus_rvalid),
        .evt_i        (evt),
        .irq_o        (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a;
        bus_wdata = {d, 32'hA5A5_5A5A};
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
        check("R10 low half", bus_rdata[31:0], 32'd0);
        d = bus_rdata[63:32];
    endtask

    task automatic pulse(input logic [7:0] m, input int n);
        @(negedge clk);
        evt = m;
        for (int i = 0; i < n; i++) @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 32'd0);
        rd(3'd0, v); check("R1 control", v, 32'd0);
        rd(3'd1, v); check("R1 status", v, 32'd0);
        rd(3'd2, v); check("R1 counter0", v, 32'd0);
        pulse(8'hFF, 3);
        rd(3'd5, v); check("R1 stopped after reset", v, 32'd0);
    endtask

    task automatic t_count32();
        logic [31:0] v;
        wr(3'd0, 32'h8000_0000);
        pulse(8'h11, 5);
        rd(3'd2, v); check("R2 count32", v, 32'd5);
        rd(3'd3, v); check("R2 other counter idle", v, 32'd0);
        wr(3'd0, 32'h0000_0000);
        pulse(8'h01, 3);
        rd(3'd2, v); check("R2 stopped holds", v, 32'd5);
    endtask

    task automatic t_latch();
        logic [31:0] v;
        wr(3'd0, 32'h8000_0000);
        wr(3'd4, 32'h0000_0100);
        rd(3'd4, v); check("R4 live not latch", v, 32'd0);
        pulse(8'h04, 2);
        rd(3'd4, v); check("R4 old value counts", v, 32'd2);
        wr(3'd0, 32'h8000_0000);
        rd(3'd4, v); check("R5 rewrite commits", v, 32'h100);
        pulse(8'h04, 1);
        rd(3'd4, v); check("R5 counts after commit", v, 32'h101);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0000);
        wr(3'd5, 32'h0000_0055);
        wr(3'd0, 32'h0000_0000);
        rd(3'd5, v); check("R6 no commit when stopped", v, 32'd0);
        pulse(8'h08, 2);
        rd(3'd5, v); check("R6 stopped no count", v, 32'd0);
        wr(3'd0, 32'h8000_0000);
        rd(3'd5, v); check("R6 later run commits", v, 32'h55);
    endtask

    task automatic t_split();
        logic [31:0] v;
        wr(3'd1, 32'h0000_00FF);
        wr(3'd2, 32'h0001_FFFE);
        wr(3'd0, 32'h8000_0001);
        rd(3'd0, v); check("R3 control readback", v, 32'h8000_0001);
        pulse(8'h10, 3);
        rd(3'd2, v); check("R3 lower wraps no carry", v, 32'h0001_0001);
        check("R9 irq on enabled flag", {31'b0, irq}, 32'd1);
        pulse(8'h01, 2);
        rd(3'd2, v); check("R3 upper counts own event", v, 32'h0003_0001);
        rd(3'd1, v); check("R7 lower half flag bit4", v, 32'h10);
        check("R8 irq low after read", {31'b0, irq}, 32'd0);
        rd(3'd1, v); check("R8 flags cleared", v, 32'd0);
    endtask

    task automatic t_ovf32();
        logic [31:0] v;
        wr(3'd0, 32'h8000_0000);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h8000_0000);
        pulse(8'h02, 1);
        rd(3'd3, v); check("R7 32-bit wrap", v, 32'd0);
        check("R9 irq after overflow", {31'b0, irq}, 32'd1);
        wr(3'd1, 32'h0000_0000);
        check("R9 zero mask drops irq", {31'b0, irq}, 32'd0);
        rd(3'd1, v); check("R8 flag kept until read", v, 32'h02);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h8000_0000);
        pulse(8'h02, 1);
        rd(3'd3, v); check("R7 wrap with mask off", v, 32'd0);
        check("R7 no irq when masked", {31'b0, irq}, 32'd0);
        rd(3'd1, v); check("R7 masked wrap no flag", v, 32'd0);
    endtask

    task automatic t_bus();
        logic [31:0] v;
        rd(3'd0, v); check("R10 upper half data", v, 32'h8000_0000);
        rd(3'd6, v); check("R10 unmapped reads zero", v, 32'd0);
        @(negedge clk);
        check("R10 rvalid only for reads", {31'b0, bus_rvalid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count32();
        t_latch();
        t_stop();
        t_split();
        t_ovf32();
        t_bus();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule